// File: doc/BRIEF.md
# Byte-Serial Result Readout Unit

This unit returns a wide arithmetic sum to a host through an 8-bit output bus. The host puts a command on a 2-bit opcode field. When the read opcode is sampled while the unit is idle, the unit takes a snapshot of the 19-bit sum into a shadow register. The snapshot is zero-extended to 24 bits. The unit then plays the snapshot out as three bytes on three consecutive cycles, most significant byte first, and raises a valid flag while it does so.

The host rebuilds the value by shifting an accumulator left eight bits and ORing in each byte as it arrives. Because the snapshot is taken at the command, the sum may change during the transfer without corrupting it. The widths of the sum and of the output byte are parameters. The number of bytes is derived from them.

Top module: `byte_readout`

## Requirements
- R1: When `opcode` is 2'b10 (read) at a rising edge while the unit is idle, `sum_in` is captured. Later changes of `sum_in` do not affect the bytes of that readout.
- R2: On the cycle after capture, `data_out` carries snapshot bits 23:16 and `data_valid` is 1.
- R3: On the two following cycles, `data_out` carries bits 15:8 and then bits 7:0. Shifting an accumulator left 8 and ORing in each byte rebuilds the captured sum.
- R4: The snapshot is zero-extended, so bits 23:19 are 0 and the upper five bits of the first byte are always 0.
- R5: `data_valid` is 1 for exactly three consecutive cycles per readout and then returns to 0.
- R6: While idle, `data_valid` is 0 and `data_out` is 8'h00.
- R7: A read opcode sampled during any of the three byte cycles is ignored. A read opcode held continuously therefore produces one idle cycle between readouts.
- R8: Opcodes 2'b00, 2'b01 and 2'b11 never start a readout. Holding 2'b11 (no-op) during a readout does not disturb it.
- R9: The synchronous active-high `rst` returns the unit to idle with `data_out` 0 and `data_valid` 0 on the next cycle. This includes aborting a readout in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 2 | Command field; 2'b10 requests a readout |
| sum_in | input | 19 | Arithmetic result to be snapshotted |
| data_out | output | 8 | Current result byte, zero when idle |
| data_valid | output | 1 | High during the three byte cycles |

## Verification
The hardest case to reach is the boundary at the last byte of a readout. A read opcode sampled there must be dropped, and a read sampled on the very next idle cycle must start a new readout. The stimulus holds the read opcode for many cycles while changing `sum_in` every cycle. This drives the unit through repeated start, stream and ignore phases, and shows the single idle gap. A reset asserted between the first and second byte covers the aborted-readout path.

// File: rtl/readout_pkg.sv
package readout_pkg;

    // Command field encodings seen on the opcode input
    typedef enum logic [1:0] {
        OP_WR_LO = 2'b00,
        OP_WR_HI = 2'b01,
        OP_READ  = 2'b10,
        OP_IDLE  = 2'b11
    } cmd_op_e;

    localparam int SEQ_IDX_W = 8;

    // Sequencer state: active flag plus index of the byte on the bus
    typedef struct packed {
        logic                 active;
        logic [SEQ_IDX_W-1:0] idx;
    } seq_state_t;

    function automatic int bytes_for(input int value_w, input int byte_w);
        return (value_w + byte_w - 1) / byte_w;
    endfunction

endpackage

// File: rtl/rdo_cmd_decode.sv
module rdo_cmd_decode
    import readout_pkg::*;
(
    input  logic [1:0] opcode,
    input  logic       busy,
    output logic       start
);
    cmd_op_e op;

    always_comb begin
        op    = cmd_op_e'(opcode);
        start = (op == OP_READ) && !busy;
    end

endmodule

// File: rtl/rdo_sequencer.sv
module rdo_sequencer
    import readout_pkg::*;
#(
    parameter int NBYTES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_t st
);
    localparam logic [SEQ_IDX_W-1:0] LAST_IDX = SEQ_IDX_W'(NBYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start) begin
            st.active <= 1'b1;
            st.idx    <= LAST_IDX;
        end else if (st.active) begin
            if (st.idx == '0) begin
                st.active <= 1'b0;
            end else begin
                st.idx <= st.idx - 1'b1;
            end
        end
    end

    // R2
    start_to_msb_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (st.active && st.idx == LAST_IDX));

    // R5
    end_of_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && st.idx == '0) |=> !st.active);

    // R3
    descend_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && st.idx != '0) |=> (st.active && st.idx == $past(st.idx) - 1'b1));

endmodule

// File: rtl/rdo_shadow.sv
module rdo_shadow #(
    parameter int SUM_W    = 19,
    parameter int SHADOW_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                hold,
    input  logic [SUM_W-1:0]    sum_in,
    output logic [SHADOW_W-1:0] shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (start) begin
            shadow <= SHADOW_W'(sum_in);
        end
    end

    // R1 R4
    capture_zext_chk: assert property (@(posedge clk) disable iff (rst)
        $past(start && !rst) |-> (shadow == SHADOW_W'($past(sum_in))));

    // R1 R7
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !start) |=> $stable(shadow));

endmodule

// File: rtl/rdo_byte_mux.sv
module rdo_byte_mux
    import readout_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3
) (
    input  logic [NBYTES*BYTE_W-1:0] shadow,
    input  seq_state_t               st,
    output logic [BYTE_W-1:0]        data_out
);
    logic [BYTE_W-1:0] lane [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = shadow[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        data_out = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (st.active && st.idx == SEQ_IDX_W'(i)) begin
                data_out = lane[i];
            end
        end
    end

endmodule

// File: rtl/byte_readout.sv
module byte_readout
    import readout_pkg::*;
#(
    parameter int SUM_W  = 19,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        opcode,
    input  logic [SUM_W-1:0]  sum_in,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_valid
);
    localparam int NBYTES   = bytes_for(SUM_W, BYTE_W);
    localparam int SHADOW_W = NBYTES * BYTE_W;

    logic                start;
    seq_state_t          st;
    logic [SHADOW_W-1:0] shadow;

    rdo_cmd_decode u_dec (
        .opcode (opcode),
        .busy   (st.active),
        .start  (start)
    );

    rdo_sequencer #(.NBYTES(NBYTES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .st    (st)
    );

    rdo_shadow #(.SUM_W(SUM_W), .SHADOW_W(SHADOW_W)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .hold   (st.active),
        .sum_in (sum_in),
        .shadow (shadow)
    );

    rdo_byte_mux #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_mux (
        .shadow   (shadow),
        .st       (st),
        .data_out (data_out)
    );

    assign data_valid = st.active;

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> (data_out == '0));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!data_valid && data_out == '0));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (data_valid && $past(data_valid) && opcode == 2'b10) |=> $stable(u_shadow.shadow));

endmodule

// File: tb/byte_readout_bench.sv
module byte_readout_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  opcode = 2'b11;
    logic [18:0] sum_in = '0;
    logic [7:0]  data_out;
    logic        data_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R9";
    bit done = 0;

    byte_readout u_byte_readout (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .sum_in     (sum_in),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

    always #10 clk = ~clk;

    // Behavioural reference: queue of bytes still to appear on the bus
    logic [7:0] q [$];

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
        end else if (q.size() != 0) begin
            void'(q.pop_front());
        end else if (opcode == 2'b10) begin
            logic [23:0] v;
            v = {5'b0, sum_in};
            q.push_back(v[23:16]);
            q.push_back(v[15:8]);
            q.push_back(v[7:0]);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] eb;
            eb = (q.size() != 0) ? q[0] : 8'h00;
            check(cur_req, {31'b0, data_valid}, {31'b0, (q.size() != 0)}, "valid");
            check(cur_req, {24'b0, data_out}, {24'b0, eb}, "data");
        end
    end

    task automatic summary();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
            summary();
        end
    end

    // Directed read with host-style reassembly
    task automatic host_read(input logic [18:0] val, input string req);
        logic [23:0] acc;
        acc = '0;
        opcode = 2'b10;
        sum_in = val;
        @(negedge clk);
        opcode = 2'b11;
        for (int i = 0; i < 3; i++) begin
            sum_in = ~sum_in;
            if (i == 0) check("R4", {27'b0, data_out[7:3]}, 32'h0, "zero pad bits");
            acc = (acc << 8) | {16'b0, data_out};
            @(negedge clk);
        end
        check(req, {8'b0, acc}, {13'b0, val}, "reassembled");
        check("R5", {31'b0, data_valid}, 32'h0, "valid after three bytes");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R9";
        rst = 1'b0;
        @(negedge clk);
        check("R6", {24'b0, data_out}, 32'h0, "idle data");

        cur_req = "R2";
        host_read(19'h5A3C7, "R3");
        cur_req = "R4";
        host_read(19'h7FFFF, "R3");
        host_read(19'h00001, "R3");

        cur_req = "R8";
        for (int i = 0; i < 12; i++) begin
            opcode = 2'(i % 4 == 2 ? 3 : i % 4);
            sum_in = 19'(i * 4099);
            @(negedge clk);
        end
        check("R8", {31'b0, data_valid}, 32'h0, "no start from other ops");

        cur_req = "R7";
        opcode = 2'b10;
        for (int i = 0; i < 20; i++) begin
            sum_in = 19'(i * 31337 + 5);
            @(negedge clk);
        end
        opcode = 2'b11;
        repeat (4) @(negedge clk);

        cur_req = "R9";
        opcode = 2'b10;
        sum_in = 19'h2BEEF;
        @(negedge clk);
        opcode = 2'b11;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9", {31'b0, data_valid}, 32'h0, "abort on reset");
        repeat (3) @(negedge clk);

        cur_req = "R1";
        for (int i = 0; i < 25; i++) begin
            opcode = 2'b10;
            sum_in = 19'((i * 77777) ^ (i << 11));
            @(negedge clk);
            opcode = 2'(i % 2 == 0 ? 3 : 0);
            for (int k = 0; k < 3; k++) begin
                sum_in = sum_in + 19'd12345;
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        summary();
    end

endmodule